// File: doc/BRIEF.md
# Seventh-Order Recursive Lowpass Filter

This block filters a stream of signed audio samples with a seventh-order recursive (IIR) lowpass in direct form. A sample from a converter-style source arrives with a one-cycle valid strobe. The block then produces one filtered sample, also marked by a one-cycle valid strobe, for a converter-style sink.

The numerator has all seven zeros at z = -1, so its taps follow the binomial row 1, 7, 21, 35, 35, 21, 7, 1 under one common gain. Input taps that share a weight are added together first, so the feedforward side needs four constant-weight terms and one general gain multiply. The seven recursive coefficients are general signed fixed-point parameters. By default they use a 16-bit word with 10 fractional bits, which holds magnitudes up to 32. The gain uses a 16-bit word with 30 fractional bits by default.

Products are summed at full precision. The sum is rounded once to the sample width and clipped at the signed limits. That rounded value is both the output and the value stored in the feedback history.

Top module: `iir7_lowpass`

## Requirements
- R1: For every accepted input sample x(n), the output is y(n) = sat(rnd((G·Σ_{p=0..3} C(7,p)·(x(n-p)+x(n-7+p)) + 2^(GAIN_FRAC-COEF_FRAC)·Σ_{k=1..7} b_k·y(n-k)) / 2^GAIN_FRAC)), where:
  - G is FF_GAIN, a signed value with GAIN_FRAC fractional bits.
  - b_k is the signed slice FB_COEF[(k-1)*COEF_W +: COEF_W], so b1 sits at the least significant bits. It has COEF_FRAC fractional bits.
  - x and y earlier than the last reset count as zero.
  - y(n-k) are the values the block emitted earlier.
- R2: out_valid is high for exactly one cycle, on the second rising clock edge after the edge that accepts in_valid. out_y takes its new value in that cycle and holds it in every other cycle.
- R3: Rounding goes to the nearest integer. A fraction of exactly one half rounds toward plus infinity, so 7.5 becomes 8 and -7.5 becomes -7.
- R4: A result outside the signed DATA_W range is clipped to 2^(DATA_W-1)-1 or to -2^(DATA_W-1). For 16 bits these are 32767 and -32768.
- R5: in_valid raised in the cycle right after an accepted sample is ignored. No extra output is produced, and that sample never enters the input history.
- R6: A synchronous active-high reset clears both delay lines and drives out_valid and out_y to 0. The first impulse after reset therefore meets a filter at rest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking a new input sample |
| in_x | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Strobe marking a new filtered sample |
| out_y | output | DATA_W | Signed filtered sample, held between strobes |

## Verification
- **Impulse.** An impulse of 16 followed by zeros yields the scaled binomial numerator mixed with a two-tap feedback. Hand-computed values separate a wrong tap pairing, a wrong weight and a wrong feedback order.
- **Tie impulses.** Impulses of +1 and -1 produce feedback fractions of exactly one half. They separate half-up rounding from truncation or rounding away from zero.
- **Long steps.** Long positive and negative steps drive the recursion into both clip limits. They also exercise the clipped value re-entering the history.
- **Back-to-back strobe and reset.** A strobe in the busy cycle, and a reset in the middle of a stream, show whether stale samples leak into either delay line.

// File: rtl/iir7_pkg.sv
package iir7_pkg;
    localparam int ORDER   = 7;
    localparam int NPAIR   = (ORDER + 1) / 2;
    localparam int LATENCY = 2;

    // Binomial coefficient C(ORDER, k), built from the running product.
    function automatic int binom_w(input int k);
        int r;
        r = 1;
        for (int i = 0; i < k; i++) begin
            r = r * (ORDER - i) / (i + 1);
        end
        return r;
    endfunction

    typedef enum logic [1:0] {
        SAT_NONE = 2'd0,
        SAT_HIGH = 2'd1,
        SAT_LOW  = 2'd2
    } sat_e;
endpackage

// File: rtl/iir7_delay.sv
module iir7_delay #(
    parameter int W     = 16,
    parameter int DEPTH = 7
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      shift,
    input  logic signed [W-1:0]       din,
    output logic [DEPTH-1:0][W-1:0]   taps
);
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    taps[i] <= '0;
                end else if (shift) begin
                    if (i == 0) begin
                        taps[i] <= din;
                    end else begin
                        taps[i] <= taps[(i == 0) ? 0 : i - 1];
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/iir7_feedfwd.sv
module iir7_feedfwd
    import iir7_pkg::*;
#(
    parameter int                       DW   = 16,
    parameter int                       GW   = 16,
    parameter int                       FF_W = GW + DW + 8,
    parameter logic signed [GW-1:0]     GAIN = '0
) (
    input  logic signed [DW-1:0]        x_now,
    input  logic [ORDER-1:0][DW-1:0]    x_hist,
    output logic signed [FF_W-1:0]      ff
);
    localparam int WS_W = DW + 8;

    logic signed [DW-1:0]   tap   [ORDER+1];
    logic signed [WS_W-1:0] term  [NPAIR];
    logic signed [WS_W-1:0] wsum;

    assign tap[0] = x_now;
    generate
        for (genvar k = 1; k <= ORDER; k++) begin : g_tap
            assign tap[k] = $signed(x_hist[k-1]);
        end
        for (genvar p = 0; p < NPAIR; p++) begin : g_pair
            logic signed [WS_W-1:0] pair_sum;
            logic signed [WS_W-1:0] weight;
            assign weight   = WS_W'(binom_w(p));
            assign pair_sum = WS_W'(tap[p]) + WS_W'(tap[ORDER-p]);
            assign term[p]  = pair_sum * weight;
        end
    endgenerate

    always_comb begin
        wsum = '0;
        for (int p = 0; p < NPAIR; p++) begin
            wsum = wsum + term[p];
        end
    end

    assign ff = FF_W'(GAIN) * FF_W'(wsum);
endmodule

// File: rtl/iir7_feedback.sv
module iir7_feedback
    import iir7_pkg::*;
#(
    parameter int                       DW   = 16,
    parameter int                       CW   = 16,
    parameter int                       FB_W = CW + DW + 3,
    parameter logic [ORDER*CW-1:0]      COEF = '0
) (
    input  logic [ORDER-1:0][DW-1:0]    y_hist,
    output logic signed [FB_W-1:0]      fb
);
    logic signed [FB_W-1:0] term [ORDER];

    generate
        for (genvar k = 0; k < ORDER; k++) begin : g_tap
            logic signed [CW-1:0] c_k;
            assign c_k     = $signed(COEF[k*CW +: CW]);
            assign term[k] = FB_W'(c_k) * FB_W'($signed(y_hist[k]));
        end
    endgenerate

    always_comb begin
        fb = '0;
        for (int k = 0; k < ORDER; k++) begin
            fb = fb + term[k];
        end
    end
endmodule

// File: rtl/iir7_lowpass.sv
module iir7_lowpass
    import iir7_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int COEF_W    = 16,
    parameter int COEF_FRAC = 10,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 30,
    parameter logic signed [GAIN_W-1:0] FF_GAIN = 16'sd8590,
    parameter logic [7*COEF_W-1:0] FB_COEF = {
        16'sd488, -16'sd3572, 16'sd10776, -16'sd18729,
        16'sd20504, -16'sd14091, 16'sd5647
    }
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_x,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_y
);
    localparam int FF_W  = GAIN_W + DATA_W + 8;
    localparam int FB_W  = COEF_W + DATA_W + 3;
    localparam int ALIGN = GAIN_FRAC - COEF_FRAC;
    localparam int ACC_W = ((FF_W > FB_W + ALIGN) ? FF_W : FB_W + ALIGN) + 1;
    localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] Y_MIN = ~Y_MAX;
    localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1) <<< (GAIN_FRAC - 1);

    typedef struct packed {
        logic                    busy;
        logic signed [ACC_W-1:0] acc;
    } stage_t;

    stage_t                       st;
    logic                         busy;
    logic                         accept;
    logic [ORDER-1:0][DATA_W-1:0] x_hist;
    logic [ORDER-1:0][DATA_W-1:0] y_hist;
    logic signed [FF_W-1:0]       ff;
    logic signed [FB_W-1:0]       fb;
    logic signed [ACC_W-1:0]      acc_sum;
    logic signed [ACC_W-1:0]      rnd;
    logic signed [ACC_W-1:0]      quo;
    sat_e                         sat_kind;
    logic signed [DATA_W-1:0]     y_next;

    assign busy   = st.busy;
    assign accept = in_valid & ~busy;

    iir7_delay #(.W(DATA_W), .DEPTH(ORDER)) u_xline (
        .clk(clk), .rst(rst), .shift(accept), .din(in_x), .taps(x_hist)
    );

    iir7_delay #(.W(DATA_W), .DEPTH(ORDER)) u_yline (
        .clk(clk), .rst(rst), .shift(busy), .din(y_next), .taps(y_hist)
    );

    iir7_feedfwd #(.DW(DATA_W), .GW(GAIN_W), .FF_W(FF_W), .GAIN(FF_GAIN)) u_ff (
        .x_now(in_x), .x_hist(x_hist), .ff(ff)
    );

    iir7_feedback #(.DW(DATA_W), .CW(COEF_W), .FB_W(FB_W), .COEF(FB_COEF)) u_fb (
        .y_hist(y_hist), .fb(fb)
    );

    assign acc_sum = ACC_W'(ff) + (ACC_W'(fb) <<< ALIGN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.busy <= accept;
            if (accept) begin
                st.acc <= acc_sum;
            end
        end
    end

    // Half-up rounding, then clipping to the sample range.
    assign rnd = st.acc + HALF;
    assign quo = rnd >>> GAIN_FRAC;

    always_comb begin
        if (quo > Y_MAX) begin
            sat_kind = SAT_HIGH;
        end else if (quo < Y_MIN) begin
            sat_kind = SAT_LOW;
        end else begin
            sat_kind = SAT_NONE;
        end
        case (sat_kind)
            SAT_HIGH: y_next = DATA_W'(Y_MAX);
            SAT_LOW:  y_next = DATA_W'(Y_MIN);
            default:  y_next = DATA_W'(quo);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_y     <= '0;
        end else begin
            out_valid <= busy;
            if (busy) begin
                out_y <= y_next;
            end
        end
    end
endmodule

// File: rtl/iir7_chk.sv
module iir7_chk #(
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     busy,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_y
);
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        busy |=> out_valid);

    assert_source_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(busy));

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_y));

    assert_ignore_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && in_valid) |=> !busy);

    assert_reset_clear_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_y == '0 && !busy));
endmodule

bind iir7_lowpass iir7_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .busy(busy),
    .out_valid(out_valid), .out_y(out_y)
);

// File: tb/test_iir7_lowpass.sv
`timescale 1ns/1ps
module test_iir7_lowpass;
    localparam int DW = 16;
    localparam int N_IMP = 10;
    localparam int IMP_X [N_IMP] = '{16, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    localparam int IMP_Y [N_IMP] = '{16, 120, 392, 726, 825, 567, 189, -31, -63, -24};
    localparam longint GAIN = 256;
    localparam longint BQ [7] = '{128, -64, 0, 0, 0, 0, 0};
    localparam longint BW [4] = '{1, 7, 21, 35};

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_x = '0;
    logic                 out_valid;
    logic signed [DW-1:0] out_y;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;
    longint mx [8];
    longint my [7];

    always #2.5 clk = ~clk;

    iir7_lowpass #(
        .DATA_W(16), .COEF_W(16), .COEF_FRAC(8), .GAIN_W(16), .GAIN_FRAC(8),
        .FF_GAIN(16'sd256),
        .FB_COEF({16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, -16'sd64, 16'sd128})
    ) i_iir7_lowpass (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
        .out_valid(out_valid), .out_y(out_y)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 8; i++) mx[i] = 0;
        for (int i = 0; i < 7; i++) my[i] = 0;
    endtask

    task automatic model_step(input longint x, output longint y);
        longint ws, acc, q;
        for (int i = 7; i > 0; i--) mx[i] = mx[i-1];
        mx[0] = x;
        ws = 0;
        for (int p = 0; p < 4; p++) ws += BW[p] * (mx[p] + mx[7-p]);
        acc = GAIN * ws;
        for (int k = 0; k < 7; k++) acc += BQ[k] * my[k];
        q = (acc + 128) >>> 8;
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        for (int i = 6; i > 0; i--) my[i] = my[i-1];
        my[0] = q;
        y = q;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        check("R6", "out_valid after reset", longint'(out_valid), 0);
        check("R6", "out_y after reset", longint'(out_y), 0);
    endtask

    // Ends at the falling edge after the second rising edge following acceptance.
    task automatic push(input longint x, output bit mid_valid);
        @(negedge clk);
        in_valid = 1'b1; in_x = DW'(x);
        @(negedge clk);
        in_valid = 1'b0;
        mid_valid = out_valid;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        bit mv;
        longint e;
        model_clear();
        do_reset();

        // R1: impulse table, hand-computed results
        for (int i = 0; i < N_IMP; i++) begin
            push(longint'(IMP_X[i]), mv);
            model_step(longint'(IMP_X[i]), e);
            check("R1", $sformatf("impulse sample %0d", i), longint'(out_y), longint'(IMP_Y[i]));
            if (i == 0) begin
                check("R2", "no strobe one edge after accept", longint'(mv), 0);
                check("R2", "strobe two edges after accept", longint'(out_valid), 1);
                @(negedge clk);
                check("R2", "strobe lasts one cycle", longint'(out_valid), 0);
                check("R2", "out_y held after strobe", longint'(out_y), 16);
            end
        end

        // R3: half ties round toward plus infinity
        do_reset();
        push(1, mv);  check("R3", "impulse +1 y0", longint'(out_y), 1);
        push(0, mv);  check("R3", "tie +7.5", longint'(out_y), 8);
        do_reset();
        push(-1, mv); check("R3", "impulse -1 y0", longint'(out_y), -1);
        push(0, mv);  check("R3", "tie -7.5", longint'(out_y), -7);

        // R5: strobe in busy cycle is ignored
        do_reset();
        @(negedge clk);
        in_valid = 1'b1; in_x = 16'sd500;
        @(negedge clk);
        in_x = -16'sd700;
        @(negedge clk);
        in_valid = 1'b0;
        model_step(500, e);
        check("R5", "first sample strobe", longint'(out_valid), 1);
        check("R5", "first sample value", longint'(out_y), e);
        @(negedge clk);
        check("R5", "no second strobe", longint'(out_valid), 0);
        push(0, mv);
        model_step(0, e);
        check("R5", "ignored sample absent from history", longint'(out_y), e);

        // R4: clipping at both limits, with model for each step
        do_reset();
        for (int i = 0; i < 20; i++) begin
            push(1000, mv);
            model_step(1000, e);
            check("R4", $sformatf("positive step %0d", i), longint'(out_y), e);
        end
        check("R4", "positive limit", longint'(out_y), 32767);
        for (int i = 0; i < 20; i++) begin
            push(-1000, mv);
            model_step(-1000, e);
            check("R4", $sformatf("negative step %0d", i), longint'(out_y), e);
        end
        check("R4", "negative limit", longint'(out_y), -32768);

        // R6: reset in mid-stream clears both histories
        do_reset();
        push(16, mv); check("R6", "impulse after reset y0", longint'(out_y), 16);
        push(0, mv);  check("R6", "impulse after reset y1", longint'(out_y), 120);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule